// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out the state update a 32-bit RISC core makes at the moment it accepts an exception or an interrupt. A synchronous exception arrives as a request with a code, held for one cycle in a pending register. The external and timer interrupt lines are weighed against their enable bits in the current status word. When an event is accepted, the block computes the saved PC, saved status, fault address, new status and new power-management word. It also builds the vector address, and presents all of them on registered outputs with a one-cycle taken strobe.

The surrounding core applies the outputs: it writes the saved registers, loads the new PC, clears its delay-slot flag when asked, and drops its load-link reservation on the reservation-clear strobe. Output registers keep their last values between events. A pending code outside the architectural range is refused: an error strobe pulses and no output register changes.

Status word layout (bit positions): 0 supervisor mode, 1 timer-interrupt enable, 2 external-interrupt enable, 5 data-MMU enable, 6 instruction-MMU enable, 13 delay-slot exception, 14 high vector prefix. Power-management word: bit 1 doze enable, bit 2 sleep enable. Exception codes: 1 reset, 2 bus error, 3 data page fault, 4 instruction page fault, 5 tick, 6 alignment, 7 illegal instruction, 8 external interrupt, 9 data TLB miss, 10 instruction TLB miss, 11 range, 12 system call, 13 floating point, 14 trap.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request with `exc_req_i` high at a rising edge is latched and taken at the following edge; `taken_o` is then high for exactly one cycle and `cause_o` equals the latched code.
- R2: `epcr_o` receives `pc_i`, plus 4 when the code is 12 (system call), minus 4 when `dslot_i` is high; both adjustments apply together.
- R3: On entry, status bit 13 of `sr_o` and `dflag_clr_o` equal `dslot_i`.
- R4: `eear_o` is loaded with the unadjusted `pc_i` only for code 7 (illegal instruction) and keeps its value for every other entry.
- R5: `esr_o` receives `sr_i` as it was before the entry.
- R6: `sr_o` is `sr_i` with bits 1, 2, 5 and 6 cleared and bit 0 set (bit 13 per R3, others kept); `pmr_o` is `pmr_i` with bits 1 and 2 cleared; `resv_clr_o` pulses with `taken_o`.
- R7: `pc_o` is the code shifted left by 8, ORed with `vbase_i` when `vbase_en_i` is high, and ORed with 0xF0000000 when bit 14 of `sr_i` is high.
- R8: With no pending request, an external interrupt is taken as code 8 only while `sr_i` bit 2 is set, a timer interrupt as code 5 only while bit 1 is set; when both are eligible the timer wins; otherwise nothing is taken and the outputs hold.
- R9: A pending code of 0 or above 14 pulses `err_o` for one cycle, leaves `taken_o` low and changes no output register.
- R10: A pending request has priority over interrupt lines in the same cycle, even when the request's code is invalid.
- R11: During and right after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | PC of the faulting or interrupted instruction |
| sr_i | input | 16 | Current status word |
| pmr_i | input | 8 | Current power-management word |
| vbase_i | input | 32 | Vector base register |
| vbase_en_i | input | 1 | Configuration bit enabling the vector base |
| dslot_i | input | 1 | Instruction sits in a branch delay slot |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Code of the requested exception |
| irq_ext_i | input | 1 | External interrupt request line |
| irq_tmr_i | input | 1 | Timer interrupt request line |
| taken_o | output | 1 | One-cycle strobe: entry performed |
| err_o | output | 1 | One-cycle strobe: invalid pending code refused |
| cause_o | output | 4 | Code of the last entry |
| pc_o | output | 32 | New PC (vector address) |
| epcr_o | output | 32 | Saved PC |
| esr_o | output | 16 | Saved status word |
| eear_o | output | 32 | Effective-address register |
| sr_o | output | 16 | New status word |
| pmr_o | output | 8 | New power-management word |
| dflag_clr_o | output | 1 | Strobe: clear the core's delay-slot flag |
| resv_clr_o | output | 1 | Strobe: invalidate the load-link reservation |

## Verification
A synchronous request's results are due two edges after the request is driven: one edge latches it, the next registers the entry. Interrupt results are due one edge after the lines are driven. The bench drives on falling edges and samples on the falling edge after the due rising edge, then samples once more a cycle later to confirm that the strobes have dropped. Interrupt lines for the priority case are raised only in the cycle the request is pending, so both sources meet at the same arbitration edge.

// File: rtl/exc_entry_pkg.sv
// Package: exception codes and status-word bit positions shared by the
// exception entry controller, its sub-blocks and its checker.
package exc_entry_pkg;

    // Exception codes (architectural numbering, used for vectoring)
    localparam int EXC_RESET   = 1;
    localparam int EXC_BUSERR  = 2;
    localparam int EXC_DPAGE   = 3;
    localparam int EXC_IPAGE   = 4;
    localparam int EXC_TICK    = 5;
    localparam int EXC_ALIGN   = 6;
    localparam int EXC_ILLEGAL = 7;
    localparam int EXC_EXTINT  = 8;
    localparam int EXC_DTLB    = 9;
    localparam int EXC_ITLB    = 10;
    localparam int EXC_RANGE   = 11;
    localparam int EXC_SYSCALL = 12;
    localparam int EXC_FPU     = 13;
    localparam int EXC_TRAP    = 14;

    // Status word bit positions
    localparam int SR_SUPV   = 0;
    localparam int SR_TMR_EN = 1;
    localparam int SR_INT_EN = 2;
    localparam int SR_DMMU   = 5;
    localparam int SR_IMMU   = 6;
    localparam int SR_DSLOT  = 13;
    localparam int SR_VHIGH  = 14;

    // Power-management word bit positions
    localparam int PM_DOZE  = 1;
    localparam int PM_SLEEP = 2;

endpackage

// File: rtl/exc_cause_arb.sv
// Cause arbiter: chooses which event, if any, is entered this cycle.
// Assumes the pending request lasts one cycle; a pending request always
// wins over the interrupt lines, timer wins over external interrupt.
module exc_cause_arb
    import exc_entry_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int NUM_CODES = 14
) (
    input  logic              pend_vld_i,
    input  logic [CODE_W-1:0] pend_code_i,
    input  logic              irq_ext_i,
    input  logic              irq_tmr_i,
    input  logic              int_en_i,
    input  logic              tmr_en_i,
    output logic              fire_o,
    output logic              bad_o,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] MAX_CODE  = CODE_W'(NUM_CODES);
    localparam logic [CODE_W-1:0] TICK_CODE = CODE_W'(EXC_TICK);
    localparam logic [CODE_W-1:0] EXT_CODE  = CODE_W'(EXC_EXTINT);

    // Priority select: pending request, then timer, then external line
    always_comb begin
        fire_o = 1'b0;
        bad_o  = 1'b0;
        code_o = '0;
        if (pend_vld_i) begin
            if (pend_code_i == '0 || pend_code_i > MAX_CODE) begin
                bad_o = 1'b1;
            end else begin
                fire_o = 1'b1;
                code_o = pend_code_i;
            end
        end else if (irq_tmr_i && tmr_en_i) begin
            fire_o = 1'b1;
            code_o = TICK_CODE;
        end else if (irq_ext_i && int_en_i) begin
            fire_o = 1'b1;
            code_o = EXT_CODE;
        end
    end

endmodule

// File: rtl/exc_save_calc.sv
// Save-state calculator: derives saved PC, new status, new power word and
// the fault-address write enable for the selected code. Purely combinational;
// assumes the status and power words carry the bit layout of exc_entry_pkg.
module exc_save_calc
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int SR_W   = 16,
    parameter int PMR_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic [PMR_W-1:0]  pmr_i,
    input  logic              dslot_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   epc_o,
    output logic [SR_W-1:0]   sr_o,
    output logic [PMR_W-1:0]  pmr_o,
    output logic              eear_we_o
);

    localparam logic [XLEN-1:0]   INSN_BYTES = XLEN'(4);
    localparam logic [CODE_W-1:0] SYS_CODE   = CODE_W'(EXC_SYSCALL);
    localparam logic [CODE_W-1:0] ILL_CODE   = CODE_W'(EXC_ILLEGAL);

    // Saved PC: skip past a system call, step back over a delay slot
    always_comb begin
        epc_o = pc_i;
        if (code_i == SYS_CODE) epc_o = epc_o + INSN_BYTES;
        if (dslot_i)            epc_o = epc_o - INSN_BYTES;
    end

    // New status: drop translation and interrupt enables, enter supervisor
    always_comb begin
        sr_o            = sr_i;
        sr_o[SR_DMMU]   = 1'b0;
        sr_o[SR_IMMU]   = 1'b0;
        sr_o[SR_INT_EN] = 1'b0;
        sr_o[SR_TMR_EN] = 1'b0;
        sr_o[SR_SUPV]   = 1'b1;
        sr_o[SR_DSLOT]  = dslot_i;
    end

    // New power word: leave doze and sleep disabled
    always_comb begin
        pmr_o           = pmr_i;
        pmr_o[PM_DOZE]  = 1'b0;
        pmr_o[PM_SLEEP] = 1'b0;
    end

    // Fault address is captured only for an illegal instruction
    assign eear_we_o = (code_i == ILL_CODE);

endmodule

// File: rtl/exc_vec_gen.sv
// Vector generator: code shifted into the vector slot, ORed with the
// optional base and the high prefix. Assumes the base leaves the code
// field clear, so OR rather than add is used (no carry chain).
module exc_vec_gen #(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 4,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_PREFIX = 'hF000_0000
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   vbase_i,
    input  logic              vbase_en_i,
    input  logic              vhigh_i,
    output logic [XLEN-1:0]   vec_o
);

    localparam int TOP_PAD = XLEN - CODE_W - VEC_SHIFT;

    logic [XLEN-1:0] slot;

    // Place the code above the per-vector spacing
    assign slot = {{TOP_PAD{1'b0}}, code_i, {VEC_SHIFT{1'b0}}};

    // Merge base and prefix
    assign vec_o = slot
                 | (vbase_en_i ? vbase_i   : '0)
                 | (vhigh_i    ? HI_PREFIX : '0);

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller (top). Latches a synchronous request for one
// cycle, arbitrates it against the interrupt lines, and registers the
// complete entry state with one-cycle strobes. Assumes the core applies the
// outputs on taken_o and holds pc_i/sr_i for the arbitration cycle.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              SR_W      = 16,
    parameter int              PMR_W     = 8,
    parameter int              CODE_W    = 4,
    parameter int              NUM_CODES = 14,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_PREFIX = 'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic [PMR_W-1:0]  pmr_i,
    input  logic [XLEN-1:0]   vbase_i,
    input  logic              vbase_en_i,
    input  logic              dslot_i,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_ext_i,
    input  logic              irq_tmr_i,
    output logic              taken_o,
    output logic              err_o,
    output logic [CODE_W-1:0] cause_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   epcr_o,
    output logic [SR_W-1:0]   esr_o,
    output logic [XLEN-1:0]   eear_o,
    output logic [SR_W-1:0]   sr_o,
    output logic [PMR_W-1:0]  pmr_o,
    output logic              dflag_clr_o,
    output logic              resv_clr_o
);

    logic              pend_vld_q;
    logic [CODE_W-1:0] pend_code_q;
    logic              fire;
    logic              bad;
    logic [CODE_W-1:0] sel_code;
    logic [XLEN-1:0]   epc_nx;
    logic [SR_W-1:0]   sr_nx;
    logic [PMR_W-1:0]  pmr_nx;
    logic              eear_we;
    logic [XLEN-1:0]   vec_nx;

    // Pending register: holds a request for exactly one cycle, then is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_q  <= 1'b0;
            pend_code_q <= '0;
        end else begin
            pend_vld_q  <= exc_req_i;
            pend_code_q <= exc_code_i;
        end
    end

    exc_cause_arb #(
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES)
    ) u_arb (
        .pend_vld_i  (pend_vld_q),
        .pend_code_i (pend_code_q),
        .irq_ext_i   (irq_ext_i),
        .irq_tmr_i   (irq_tmr_i),
        .int_en_i    (sr_i[SR_INT_EN]),
        .tmr_en_i    (sr_i[SR_TMR_EN]),
        .fire_o      (fire),
        .bad_o       (bad),
        .code_o      (sel_code)
    );

    exc_save_calc #(
        .XLEN   (XLEN),
        .SR_W   (SR_W),
        .PMR_W  (PMR_W),
        .CODE_W (CODE_W)
    ) u_calc (
        .pc_i      (pc_i),
        .sr_i      (sr_i),
        .pmr_i     (pmr_i),
        .dslot_i   (dslot_i),
        .code_i    (sel_code),
        .epc_o     (epc_nx),
        .sr_o      (sr_nx),
        .pmr_o     (pmr_nx),
        .eear_we_o (eear_we)
    );

    exc_vec_gen #(
        .XLEN      (XLEN),
        .CODE_W    (CODE_W),
        .VEC_SHIFT (VEC_SHIFT),
        .HI_PREFIX (HI_PREFIX)
    ) u_vec (
        .code_i     (sel_code),
        .vbase_i    (vbase_i),
        .vbase_en_i (vbase_en_i),
        .vhigh_i    (sr_i[SR_VHIGH]),
        .vec_o      (vec_nx)
    );

    // Strobes: one cycle per arbitration result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o     <= 1'b0;
            err_o       <= 1'b0;
            dflag_clr_o <= 1'b0;
            resv_clr_o  <= 1'b0;
        end else begin
            taken_o     <= fire;
            err_o       <= bad;
            dflag_clr_o <= fire && dslot_i;
            resv_clr_o  <= fire;
        end
    end

    // Entry state: loaded only when an event is taken, otherwise held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o <= '0;
            pc_o    <= '0;
            epcr_o  <= '0;
            esr_o   <= '0;
            eear_o  <= '0;
            sr_o    <= '0;
            pmr_o   <= '0;
        end else if (fire) begin
            cause_o <= sel_code;
            pc_o    <= vec_nx;
            epcr_o  <= epc_nx;
            esr_o   <= sr_i;
            sr_o    <= sr_nx;
            pmr_o   <= pmr_nx;
            if (eear_we) eear_o <= pc_i;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Checker for exc_entry_ctrl: temporal properties over its ports.
// Attached by the bind statement at the end of this file.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int SR_W   = 16,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_i,
    input logic [SR_W-1:0]   sr_i,
    input logic              dslot_i,
    input logic              taken_o,
    input logic              err_o,
    input logic [CODE_W-1:0] cause_o,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   epcr_o,
    input logic [SR_W-1:0]   esr_o,
    input logic [SR_W-1:0]   sr_o,
    input logic              dflag_clr_o,
    input logic              resv_clr_o
);

    localparam logic [CODE_W-1:0] SYS_CODE = CODE_W'(EXC_SYSCALL);

    // R9: taken and refused never coincide
    assert_taken_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && err_o));

    // R9: a refused code leaves the entry state untouched
    assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(pc_o) && $stable(epcr_o) && $stable(esr_o) && $stable(sr_o)));

    // R6: new status has enables off, supervisor on, reservation dropped
    assert_new_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (sr_o[SR_SUPV] && !sr_o[SR_INT_EN] && !sr_o[SR_TMR_EN]
                     && !sr_o[SR_DMMU] && !sr_o[SR_IMMU] && resv_clr_o));

    // R3: delay-slot status bit and flag clear follow the delay-slot input
    assert_dslot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (sr_o[SR_DSLOT] == $past(dslot_i) && dflag_clr_o == $past(dslot_i)));

    // R2: plain entry saves the PC unchanged
    assert_epc_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && cause_o != SYS_CODE && !sr_o[SR_DSLOT]) |-> epcr_o == $past(pc_i));

    // R5: saved status is the status seen at the arbitration edge
    assert_esr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> esr_o == $past(sr_i));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN   (XLEN),
    .SR_W   (SR_W),
    .CODE_W (CODE_W)
) u_exc_entry_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .dslot_i     (dslot_i),
    .taken_o     (taken_o),
    .err_o       (err_o),
    .cause_o     (cause_o),
    .pc_o        (pc_o),
    .epcr_o      (epcr_o),
    .esr_o       (esr_o),
    .sr_o        (sr_o),
    .dflag_clr_o (dflag_clr_o),
    .resv_clr_o  (resv_clr_o)
);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps every code with every delay-slot / prefix / base setting,
// every interrupt-line and enable combination, and the same-cycle priority case.
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [15:0] sr_i = '0;
    logic [7:0]  pmr_i = '0;
    logic [31:0] vbase_i = '0;
    logic        vbase_en_i = 1'b0;
    logic        dslot_i = 1'b0;
    logic        exc_req_i = 1'b0;
    logic [3:0]  exc_code_i = '0;
    logic        irq_ext_i = 1'b0;
    logic        irq_tmr_i = 1'b0;
    logic        taken_o, err_o, dflag_clr_o, resv_clr_o;
    logic [3:0]  cause_o;
    logic [31:0] pc_o, epcr_o, eear_o;
    logic [15:0] esr_o, sr_o;
    logic [7:0]  pmr_o;

    int n_chk = 0;
    int n_err = 0;

    // Expected held state
    logic [3:0]  e_cause = '0;
    logic [31:0] e_pc = '0, e_epcr = '0, e_eear = '0;
    logic [15:0] e_esr = '0, e_sr = '0;
    logic [7:0]  e_pmr = '0;

    always #2 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sr_i(sr_i), .pmr_i(pmr_i),
        .vbase_i(vbase_i), .vbase_en_i(vbase_en_i), .dslot_i(dslot_i),
        .exc_req_i(exc_req_i), .exc_code_i(exc_code_i),
        .irq_ext_i(irq_ext_i), .irq_tmr_i(irq_tmr_i),
        .taken_o(taken_o), .err_o(err_o), .cause_o(cause_o), .pc_o(pc_o),
        .epcr_o(epcr_o), .esr_o(esr_o), .eear_o(eear_o), .sr_o(sr_o),
        .pmr_o(pmr_o), .dflag_clr_o(dflag_clr_o), .resv_clr_o(resv_clr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected entry, computed from the requirements
    task automatic model_entry(input int code, input logic ds);
        logic [15:0] s;
        e_cause = code[3:0];
        e_epcr  = pc_i + ((code == 12) ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
        if (code == 7) e_eear = pc_i;
        e_esr   = sr_i;
        s       = (sr_i & ~16'h0066) | 16'h0001;
        s[13]   = ds;
        e_sr    = s;
        e_pmr   = pmr_i & ~8'h06;
        e_pc    = (32'(code) << 8) | (vbase_en_i ? vbase_i : 32'd0)
                | (sr_i[14] ? 32'hF000_0000 : 32'd0);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " cause"}, 32'(cause_o), 32'(e_cause));
        chk({tag, " R7 vector"}, pc_o, e_pc);
        chk({tag, " R2 epcr"}, epcr_o, e_epcr);
        chk({tag, " R5 esr"}, 32'(esr_o), 32'(e_esr));
        chk({tag, " R4 eear"}, eear_o, e_eear);
        chk({tag, " R6 sr"}, 32'(sr_o), 32'(e_sr));
        chk({tag, " R6 pmr"}, 32'(pmr_o), 32'(e_pmr));
    endtask

    // Synchronous request: drive, latch edge, entry edge, then strobe-drop check
    task automatic run_sync(input int code, input logic ds, input logic vh, input logic vb);
        logic ok;
        ok = (code >= 1) && (code <= 14);
        @(negedge clk);
        pc_i       = 32'h2000_0100 + 32'(code) * 32'h24 + (ds ? 32'h800 : 32'h0);
        sr_i       = 16'h8A77 ^ 16'(code << 9);
        sr_i[14]   = vh;
        pmr_i      = 8'hFF ^ 8'(code);
        vbase_i    = 32'h0034_5000;
        vbase_en_i = vb;
        dslot_i    = ds;
        exc_code_i = code[3:0];
        exc_req_i  = 1'b1;
        @(negedge clk);
        exc_req_i  = 1'b0;
        if (ok) model_entry(code, ds);
        @(negedge clk);
        chk($sformatf("R1 taken code=%0d", code), 32'(taken_o), 32'(ok));
        chk($sformatf("R9 err code=%0d", code), 32'(err_o), 32'(!ok));
        chk($sformatf("R3 dflag code=%0d ds=%0d", code, ds), 32'(dflag_clr_o), 32'(ok && ds));
        chk($sformatf("R6 resv code=%0d", code), 32'(resv_clr_o), 32'(ok));
        check_state($sformatf("code=%0d ds=%0d vh=%0d vb=%0d", code, ds, vh, vb));
        @(negedge clk);
        chk($sformatf("R1 single pulse code=%0d", code), 32'({taken_o, err_o, resv_clr_o}), 32'd0);
    endtask

    // Interrupt lines: drive, sample one edge later
    task automatic run_irq(input logic ext, input logic tmr, input logic ie, input logic te);
        int code;
        @(negedge clk);
        pc_i      = 32'h0040_0A00 + {28'd0, ext, tmr, ie, te} * 32'h10;
        sr_i      = 16'h4318;
        sr_i[2]   = ie;
        sr_i[1]   = te;
        pmr_i     = 8'h37;
        vbase_en_i = 1'b0;
        dslot_i   = 1'b0;
        irq_ext_i = ext;
        irq_tmr_i = tmr;
        code = (tmr && te) ? 5 : ((ext && ie) ? 8 : 0);
        if (code != 0) model_entry(code, 1'b0);
        @(negedge clk);
        irq_ext_i = 1'b0;
        irq_tmr_i = 1'b0;
        chk($sformatf("R8 taken ext=%0d tmr=%0d ie=%0d te=%0d", ext, tmr, ie, te),
            32'(taken_o), 32'(code != 0));
        check_state($sformatf("R8 ext=%0d tmr=%0d ie=%0d te=%0d", ext, tmr, ie, te));
    endtask

    // Same-cycle priority: lines rise in the cycle the request is pending
    task automatic run_prio(input int code);
        logic ok;
        ok = (code >= 1) && (code <= 14);
        @(negedge clk);
        pc_i = 32'h0077_0040; sr_i = 16'h0006; pmr_i = 8'h06;
        vbase_en_i = 1'b0; dslot_i = 1'b0;
        exc_code_i = code[3:0]; exc_req_i = 1'b1;
        @(negedge clk);
        exc_req_i = 1'b0; irq_ext_i = 1'b1; irq_tmr_i = 1'b1;
        if (ok) model_entry(code, 1'b0);
        @(negedge clk);
        irq_ext_i = 1'b0; irq_tmr_i = 1'b0;
        chk($sformatf("R10 taken code=%0d", code), 32'(taken_o), 32'(ok));
        chk($sformatf("R10 err code=%0d", code), 32'(err_o), 32'(!ok));
        check_state($sformatf("R10 code=%0d", code));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset strobes", 32'({taken_o, err_o, dflag_clr_o, resv_clr_o}), 32'd0);
        check_state("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after release", 32'({taken_o, err_o}), 32'd0);
        for (int c = 0; c < 16; c++)
            for (int m = 0; m < 8; m++)
                run_sync(c, m[0], m[1], m[2]);
        for (int k = 0; k < 16; k++)
            run_irq(k[3], k[2], k[1], k[0]);
        run_prio(3);
        run_prio(12);
        run_prio(0);
        run_prio(15);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule